// File: doc/BRIEF.md
# Multi-cycle processor control sequencer

This block is the stepping engine of a simple multi-cycle 32-bit processor controller. A three-bit state register walks through a fixed three-cycle instruction fetch (address setup with program counter advance, memory read into the data register, transfer into the instruction register) and then through zero to four execute cycles. How many execute cycles an instruction takes is carried by the three most significant opcode bits, which the surrounding controller feeds in as a cycle-length class.

The state codes are chosen so that each class value is identical to the code of the last execute state of that class. A single equality compare between the class input and the current state therefore marks the final cycle and sends the machine back to the start of fetch; no per-instruction sequencing table is needed. The block exposes the raw state code, a one-hot strobe per state and a final-cycle flag that combines the state with the class input, so that downstream output decoding can work in the Mealy style.

Top module: `ctl_seq_top`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) puts the machine in the first fetch state (code 000) on that edge, from any state including the middle of an execute sequence.
- R2: From the first fetch state the next state is the second fetch state (011), and from there the third fetch state (001), whatever the class input holds.
- R3: In the third fetch state with class 001 (fetch-only instruction) the next state is the first fetch state, so the instruction takes 3 cycles.
- R4: While the class differs from the current state, the machine advances third fetch (001) to execute 1 (010), execute 1 to execute 2 (100), execute 2 to execute 3 (110), and execute 3 to execute 4 (111).
- R5: When the current state is an execute state equal to the class, the next state is the first fetch state: class 010 gives 4 cycles, 100 gives 5, 110 gives 6 and 111 gives 7 cycles per instruction.
- R6: Execute 4 always returns to the first fetch state, so a class equal to no execute code (000, 011, 101) runs all four execute cycles, 7 cycles in total.
- R7: `o_strobe` is one-hot with bit 0 = first fetch, bit 1 = second fetch, bit 2 = third fetch, bit 3 = execute 1, bit 4 = execute 2, bit 5 = execute 3, bit 6 = execute 4.
- R8: `o_state` presents the registered state code: first fetch 000, second fetch 011, third fetch 001, execute 1 010, execute 2 100, execute 3 110, execute 4 111.
- R9: `o_last` is high, combinationally, exactly during the final cycle of each instruction (a state from third fetch onward that equals the class, or execute 4) and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| i_cls | input | 3 | Cycle-length class: top three opcode bits of the current instruction |
| o_state | output | 3 | Registered state code |
| o_strobe | output | 7 | One-hot state strobes |
| o_last | output | 1 | Final cycle of the current instruction |

## Verification
State code and strobes change one rising edge after the decision that selects them, while `o_last` follows the class input within the same cycle. The bench drives the class and reset on the falling edge and samples all three outputs on the following falling edge, half a period after the register update, so each cycle of an instruction is compared against the expected position in the fetch/execute order computed from the class alone. After the final cycle it checks one more sample to see the return to the first fetch state, and the mid-sequence reset is checked at the sample right after the edge that applied it.

// File: rtl/ctl_seq_pkg.sv
package ctl_seq_pkg;

   localparam int unsigned ST_W   = 3;
   localparam int unsigned NUM_ST = 7;

   typedef enum logic [ST_W-1:0] {
      ST_F1 = 3'b000,
      ST_F2 = 3'b011,
      ST_F3 = 3'b001,
      ST_E1 = 3'b010,
      ST_E2 = 3'b100,
      ST_E3 = 3'b110,
      ST_E4 = 3'b111,
      ST_NA = 3'b101
   } seq_st_e;

   // Position of each state in the walk order, used for strobe layout.
   function automatic seq_st_e st_at(input int unsigned idx);
      case (idx)
         0:       st_at = ST_F1;
         1:       st_at = ST_F2;
         2:       st_at = ST_F3;
         3:       st_at = ST_E1;
         4:       st_at = ST_E2;
         5:       st_at = ST_E3;
         default: st_at = ST_E4;
      endcase
   endfunction

endpackage

// File: rtl/ctl_seq_match.sv
module ctl_seq_match
   import ctl_seq_pkg::*;
#(
   parameter bit XOR_FORM = 1'b1
) (
   input  seq_st_e          st,
   input  logic [ST_W-1:0]  cls,
   output logic             hit
);
   generate
      if (XOR_FORM) begin : g_xor
         logic cont;
         assign cont = |(st ^ cls);
         assign hit  = ~cont;
      end else begin : g_eq
         assign hit = (st == cls);
      end
   endgenerate
endmodule

// File: rtl/ctl_seq_next.sv
module ctl_seq_next
   import ctl_seq_pkg::*;
(
   input  seq_st_e  st,
   input  logic     hit,
   output seq_st_e  nxt,
   output logic     last
);
   always_comb begin
      nxt  = ST_F1;
      last = 1'b0;
      case (st)
         ST_F1: nxt = ST_F2;
         ST_F2: nxt = ST_F3;
         ST_F3: begin
            last = hit;
            nxt  = hit ? ST_F1 : ST_E1;
         end
         ST_E1: begin
            last = hit;
            nxt  = hit ? ST_F1 : ST_E2;
         end
         ST_E2: begin
            last = hit;
            nxt  = hit ? ST_F1 : ST_E3;
         end
         ST_E3: begin
            last = hit;
            nxt  = hit ? ST_F1 : ST_E4;
         end
         ST_E4: begin
            last = 1'b1;
            nxt  = ST_F1;
         end
         default: begin
            last = 1'b0;
            nxt  = ST_F1;
         end
      endcase
   end
endmodule

// File: rtl/ctl_seq_decode.sv
module ctl_seq_decode
   import ctl_seq_pkg::*;
#(
   parameter int unsigned STROBE_W = NUM_ST
) (
   input  seq_st_e              st,
   output logic [STROBE_W-1:0]  strobe
);
   generate
      for (genvar i = 0; i < STROBE_W; i++) begin : g_strb
         localparam seq_st_e CODE = st_at(i);
         assign strobe[i] = (st == CODE);
      end
   endgenerate
endmodule

// File: rtl/ctl_seq_top.sv
module ctl_seq_top
   import ctl_seq_pkg::*;
#(
   parameter bit          XOR_FORM = 1'b1,
   parameter int unsigned STROBE_W = 7
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic [2:0]           i_cls,
   output logic [2:0]           o_state,
   output logic [STROBE_W-1:0]  o_strobe,
   output logic                 o_last
);
   initial begin : param_check
      assert (STROBE_W == NUM_ST)
         else $error("STROBE_W must equal the number of states");
      assert (ST_W == 3)
         else $error("state width must be 3");
   end

   seq_st_e st_q;
   seq_st_e st_d;
   logic    hit;
   logic    last;

   ctl_seq_match #(.XOR_FORM(XOR_FORM)) u_match (
      .st  (st_q),
      .cls (i_cls),
      .hit (hit)
   );

   ctl_seq_next u_next (
      .st   (st_q),
      .hit  (hit),
      .nxt  (st_d),
      .last (last)
   );

   ctl_seq_decode #(.STROBE_W(STROBE_W)) u_dec (
      .st     (st_q),
      .strobe (o_strobe)
   );

   always_ff @(posedge clk) begin
      if (rst) st_q <= ST_F1;
      else     st_q <= st_d;
   end

   assign o_state = st_q;
   assign o_last  = last;

   // R1: reset lands in first fetch
   assert_reset_f1_R1: assert property (@(posedge clk)
      rst |=> (o_state == 3'b000));

   // R2: fetch steps ignore the class
   assert_fetch_walk_R2: assert property (@(posedge clk) disable iff (rst)
      (o_state == 3'b000) |=> (o_state == 3'b011));
   assert_fetch_f3_R2: assert property (@(posedge clk) disable iff (rst)
      (o_state == 3'b011) |=> (o_state == 3'b001));

   // R3, R5: final cycle of the class returns to first fetch
   assert_last_return_R5: assert property (@(posedge clk) disable iff (rst)
      o_last |=> (o_state == 3'b000));

   // R4: execute 1 advances when the class does not end there
   assert_advance_e1_R4: assert property (@(posedge clk) disable iff (rst)
      ((o_state == 3'b010) && (i_cls != 3'b010)) |=> (o_state == 3'b100));

   // R6: execute 4 always ends the instruction
   assert_e4_exit_R6: assert property (@(posedge clk) disable iff (rst)
      (o_state == 3'b111) |=> (o_state == 3'b000));

   // R7: exactly one strobe
   assert_strobe_onehot_R7: assert property (@(posedge clk) disable iff (rst)
      $countones(o_strobe) == 1);

   // R9: final-cycle flag never set in the first two fetch cycles
   assert_last_fetch_R9: assert property (@(posedge clk) disable iff (rst)
      ((o_state == 3'b000) || (o_state == 3'b011)) |-> !o_last);

endmodule

// File: tb/tb_ctl_seq_top.sv
module tb_ctl_seq_top;
   localparam time CLK_PERIOD = 10ns;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [2:0] cls = 3'b000;
   logic [2:0] st;
   logic [6:0] strb;
   logic       last;

   int checks = 0;
   int fails  = 0;

   ctl_seq_top dut (
      .clk      (clk),
      .rst      (rst),
      .i_cls    (cls),
      .o_state  (st),
      .o_strobe (strb),
      .o_last   (last)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [2:0] code_at(input int k);
      case (k)
         0: return 3'b000;
         1: return 3'b011;
         2: return 3'b001;
         3: return 3'b010;
         4: return 3'b100;
         5: return 3'b110;
         default: return 3'b111;
      endcase
   endfunction

   function automatic int cyc_len(input logic [2:0] c);
      case (c)
         3'b001: return 3;
         3'b010: return 4;
         3'b100: return 5;
         3'b110: return 6;
         default: return 7;
      endcase
   endfunction

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // One instruction of the given class, checked cycle by cycle.
   task automatic run_instr(input logic [2:0] c, input string req);
      int n;
      n = cyc_len(c);
      cls = c;
      for (int k = 0; k < n; k++) begin
         #1;
         check({req, " R8 state"}, {5'd0, st}, {5'd0, code_at(k)});
         check({req, " R7 strobe"}, {1'b0, strb}, 8'(1 << k));
         check({req, " R9 last"}, {7'd0, last}, {7'd0, (k == n - 1)});
         @(negedge clk);
      end
      #1;
      check({req, " return to F1"}, {5'd0, st}, 8'h00);
   endtask

   task automatic reset_mid;
      cls = 3'b111;
      repeat (4) @(negedge clk);
      check("R1 pre-reset at E2", {5'd0, st}, 8'h04);
      rst = 1'b1;
      @(negedge clk);
      check("R1 mid reset state", {5'd0, st}, 8'h00);
      check("R1 mid reset strobe", {1'b0, strb}, 8'h01);
      rst = 1'b0;
      @(posedge clk);
      @(negedge clk);
      check("R1 R2 after reset", {5'd0, st}, 8'h03);
      @(posedge clk);
      @(negedge clk);
   endtask

   initial begin : watchdog
      repeat (10000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin : main
      @(negedge clk);
      @(negedge clk);
      check("R1 reset state", {5'd0, st}, 8'h00);
      check("R1 reset strobe", {1'b0, strb}, 8'h01);
      rst = 1'b0;
      run_instr(3'b001, "R3 fetch-only");
      run_instr(3'b010, "R5 one exec");
      run_instr(3'b100, "R4 R5 two exec");
      run_instr(3'b110, "R4 R5 three exec");
      run_instr(3'b111, "R4 R5 four exec");
      run_instr(3'b000, "R2 R6 class 000");
      run_instr(3'b011, "R2 R6 class 011");
      run_instr(3'b101, "R6 class 101");
      run_instr(3'b010, "R5 repeat one exec");
      // finish the last instruction's F1 before the reset scenario
      @(negedge clk);
      // now at F2 of a class-010 instruction; complete it
      cls = 3'b010;
      repeat (3) @(negedge clk);
      #1;
      check("R5 realign F1", {5'd0, st}, 8'h00);
      reset_mid();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule